// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A sixteen-state controller is clocked by the test clock `tck` and steered by the mode input `tms`. It decides which register sits between the serial input `tdi` and the serial output `tdo`. In each state it captures, shifts or updates that register. Three registers can be selected:

- a 3-bit instruction register;
- a one-stage bypass register;
- a 32-bit identification register and a configurable chain of boundary cells.

The boundary cells have a latched parallel output, `bsrOut`, that the rest of the chip would drive onto its pins.

The controller advances on the rising edge of `tck`. The instruction latch, the boundary output latch and `tdo` change on the falling edge, so every value they present is stable across the next rising edge. An active-low asynchronous `trstN` forces the whole port into its reset condition at once. Holding `tms` high for five rising edges does the same synchronously.

Top module: `scan_tap`

## Requirements
- R1: `tapState` follows the standard sixteen-state transition graph on each rising `tck` edge, under this encoding: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. Both Update states go to Select-DR when `tms` is high and to Run-Test/Idle when it is low.
- R2: Five consecutive rising edges with `tms` high bring the controller to state 0 from any state, and it stays in state 0 while `tms` remains high.
- R3: Driving `trstN` low immediately forces all of the following, without a clock edge:
  - `tapState` to 0;
  - `instr` to the IDCODE code;
  - `tdoEn` and `tdo` to 0;
  - `bsrOut` to all zeros.
- R4: In Capture-IR the instruction shift stage loads 3'b100. In Shift-IR it moves one bit toward `tdo` per rising edge, least significant bit first, with `tdi` entering at the top.
- R5: The instruction codes are EXTEST 3'b000, SAMPLE/PRELOAD 3'b001, IDCODE 3'b010 and BYPASS 3'b111. Every other code selects bypass.
  - `instrDec` is one-hot: bit 3 EXTEST, bit 2 SAMPLE/PRELOAD, bit 1 IDCODE, bit 0 bypass.
  - `instr` loads the shifted value on the falling edge while in Update-IR, and loads IDCODE on the falling edge while in Test-Logic-Reset. It holds at all other times.
- R6: With bypass selected, the data register is one stage. It captures 0, so the first bit out of a scan is 0 and each later bit is `tdi` delayed by one edge.
- R7: With IDCODE selected, Capture-DR loads `ID_VALUE`. Shift-DR presents it on `tdo` least significant bit first.
- R8: With EXTEST or SAMPLE/PRELOAD selected, Capture-DR samples `bsrIn`. Shift-DR presents bit 0 first and fills from `tdi` at the top cell.
- R9: `bsrOut` loads the boundary shift stage only on the falling `tck` edge in Update-DR, and only when EXTEST or SAMPLE/PRELOAD is selected. It is unchanged at the rising edge that enters Update-DR and under any other instruction.
- R10: `tdo` and `tdoEn` change on the falling edge. `tdoEn` is 1 exactly in Shift-DR and Shift-IR. Elsewhere `tdo` is held at 0.
- R11: Passing through Exit1, Pause and Exit2 in the middle of a data scan keeps the partially shifted contents, so the scan resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| bsrIn | input | BSR_LEN | Parallel inputs sampled by the boundary cells |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdoEn | output | 1 | High while a shift state drives `tdo` |
| tapState | output | 4 | Current controller state (encoding in R1) |
| instr | output | 3 | Current instruction code |
| instrDec | output | 4 | One-hot decoded instruction (bit order in R5) |
| bsrOut | output | BSR_LEN | Latched boundary parallel outputs |

## Verification
The bench builds the port with a six-cell boundary chain and an identification value whose bytes all differ and whose low bit is 1. The short chain lets a constrained-random walk on `tms` and `tdi` visit every state and every instruction many times within a few hundred edges. The asymmetric identification value exposes any reversal of bit order or off-by-one in the shift path. Directed scans then cover the following:

- the fixed capture pattern;
- an unrecognised code;
- a data scan paused halfway;
- the falling-edge timing of the two latches;
- a reset asserted in the middle of a shift.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

  localparam int IR_W    = 3;
  localparam int NUM_SEL = 4;

  // Instruction codes
  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b001;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b010;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b100;

  // Bit positions inside the one-hot decode
  localparam int SEL_BYPASS = 0;
  localparam int SEL_IDCODE = 1;
  localparam int SEL_SAMPLE = 2;
  localparam int SEL_EXTEST = 3;

  typedef enum logic [3:0] {
    ST_RESET  = 4'd0,
    ST_IDLE   = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tapStateT;

  // Strobes from the controller to the data registers
  typedef struct packed {
    logic capDr;
    logic shDr;
    logic updDr;
    logic capIr;
    logic shIr;
    logic updIr;
    logic inReset;
  } tapStrobeT;

endpackage

// File: rtl/scan_tap_ctrl.sv
`timescale 1ns/1ps
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic                tck,
  input  logic                trstN,
  input  logic                tms,
  input  logic                tdi,
  output tapStateT            state,
  output tapStrobeT           strobe,
  output logic [IR_W-1:0]     instr,
  output logic [NUM_SEL-1:0]  instrDec,
  output logic                irSerial
);

  tapStateT        nextState;
  logic [IR_W-1:0] irShift;
  logic [2:0]      hiCnt;

  // Transition graph
  always_comb begin
    nextState = state;
    unique case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  always_comb begin
    strobe.capDr   = (state == ST_CAP_DR);
    strobe.shDr    = (state == ST_SH_DR);
    strobe.updDr   = (state == ST_UPD_DR);
    strobe.capIr   = (state == ST_CAP_IR);
    strobe.shIr    = (state == ST_SH_IR);
    strobe.updIr   = (state == ST_UPD_IR);
    strobe.inReset = (state == ST_RESET);
  end

  // Instruction shift stage, rising edge
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            irShift <= IR_CAPTURE;
    else if (strobe.capIr) irShift <= IR_CAPTURE;
    else if (strobe.shIr)  irShift <= {tdi, irShift[IR_W-1:1]};
  end

  assign irSerial = irShift[0];

  // Instruction latch, falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)              instr <= OP_IDCODE;
    else if (strobe.inReset) instr <= OP_IDCODE;
    else if (strobe.updIr)   instr <= irShift;
  end

  always_comb begin
    instrDec = '0;
    unique case (instr)
      OP_EXTEST: instrDec[SEL_EXTEST] = 1'b1;
      OP_SAMPLE: instrDec[SEL_SAMPLE] = 1'b1;
      OP_IDCODE: instrDec[SEL_IDCODE] = 1'b1;
      default:   instrDec[SEL_BYPASS] = 1'b1;
    endcase
  end

  // Saturating count of consecutive high tms edges
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)           hiCnt <= '0;
    else if (!tms)        hiCnt <= '0;
    else if (hiCnt != 3'd5) hiCnt <= hiCnt + 3'd1;
  end

  p_tms_reset_r2: assert property (@(posedge tck) disable iff (!trstN)
    (hiCnt == 3'd5) |-> (state == ST_RESET));

  p_idle_hold_r1: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_IDLE && !tms) |=> (state == ST_IDLE));

  p_ir_capture_r4: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_CAP_IR) |=> (irShift == IR_CAPTURE));

  p_instr_hold_r5: assert property (@(posedge tck) disable iff (!trstN)
    !(state inside {ST_UPD_IR, ST_RESET}) |-> $stable(instr));

  p_dec_onehot_r5: assert property (@(posedge tck) disable iff (!trstN)
    $countones(instrDec) == 1);

endmodule

// File: rtl/scan_tap_dpath.sv
`timescale 1ns/1ps
module scan_tap_dpath
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN  = 8,
  parameter logic [31:0] ID_VALUE = 32'h4A73_601F
)(
  input  logic                tck,
  input  logic                trstN,
  input  logic                tdi,
  input  tapStrobeT           strobe,
  input  logic [NUM_SEL-1:0]  instrDec,
  input  logic                irSerial,
  input  logic [BSR_LEN-1:0]  bsrIn,
  output logic                tdo,
  output logic                tdoEn,
  output logic [BSR_LEN-1:0]  bsrOut
);

  localparam int ID_W = 32;

  logic               bypassBit;
  logic [ID_W-1:0]    idShift;
  logic [BSR_LEN-1:0] bsrShift;
  logic               selBsr;
  logic               drSerial;
  logic               serialNext;

  assign selBsr = instrDec[SEL_EXTEST] | instrDec[SEL_SAMPLE];

  // Bypass stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) bypassBit <= 1'b0;
    else if (instrDec[SEL_BYPASS]) begin
      if (strobe.capDr)     bypassBit <= 1'b0;
      else if (strobe.shDr) bypassBit <= tdi;
    end
  end

  // Identification register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) idShift <= ID_VALUE;
    else if (instrDec[SEL_IDCODE]) begin
      if (strobe.capDr)     idShift <= ID_VALUE;
      else if (strobe.shDr) idShift <= {tdi, idShift[ID_W-1:1]};
    end
  end

  // Boundary cells
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    logic shiftIn;
    if (i == BSR_LEN - 1) begin : g_top
      assign shiftIn = tdi;
    end else begin : g_mid
      assign shiftIn = bsrShift[i+1];
    end

    always_ff @(posedge tck or negedge trstN) begin
      if (!trstN) bsrShift[i] <= 1'b0;
      else if (selBsr) begin
        if (strobe.capDr)     bsrShift[i] <= bsrIn[i];
        else if (strobe.shDr) bsrShift[i] <= shiftIn;
      end
    end

    always_ff @(negedge tck or negedge trstN) begin
      if (!trstN)                      bsrOut[i] <= 1'b0;
      else if (strobe.updDr && selBsr) bsrOut[i] <= bsrShift[i];
    end
  end

  // Serial output selection
  always_comb begin
    drSerial = bypassBit;
    if (instrDec[SEL_IDCODE]) drSerial = idShift[0];
    else if (selBsr)          drSerial = bsrShift[0];
  end

  always_comb begin
    serialNext = 1'b0;
    if (strobe.shIr)      serialNext = irSerial;
    else if (strobe.shDr) serialNext = drSerial;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= serialNext;
      tdoEn <= strobe.shDr | strobe.shIr;
    end
  end

  p_bypass_zero_r6: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.capDr && instrDec[SEL_BYPASS]) |=> (bypassBit == 1'b0));

  p_bsr_hold_r9: assert property (@(posedge tck) disable iff (!trstN)
    !strobe.updDr |-> $stable(bsrOut));

  p_tdo_idle_r10: assert property (@(posedge tck) disable iff (!trstN)
    !tdoEn |-> (tdo == 1'b0));

  p_tdoen_state_r10: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (strobe.shDr || strobe.shIr));

endmodule

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN  = 8,
  parameter logic [31:0] ID_VALUE = 32'h4A73_601F
)(
  input  logic               tck,
  input  logic               trstN,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] bsrIn,
  output logic               tdo,
  output logic               tdoEn,
  output logic [3:0]         tapState,
  output logic [IR_W-1:0]    instr,
  output logic [NUM_SEL-1:0] instrDec,
  output logic [BSR_LEN-1:0] bsrOut
);

  tapStateT  stateQ;
  tapStrobeT strobe;
  logic      irSerial;

  scan_tap_ctrl u_ctrl (
    .tck      (tck),
    .trstN    (trstN),
    .tms      (tms),
    .tdi      (tdi),
    .state    (stateQ),
    .strobe   (strobe),
    .instr    (instr),
    .instrDec (instrDec),
    .irSerial (irSerial)
  );

  scan_tap_dpath #(
    .BSR_LEN  (BSR_LEN),
    .ID_VALUE (ID_VALUE)
  ) u_dpath (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .strobe   (strobe),
    .instrDec (instrDec),
    .irSerial (irSerial),
    .bsrIn    (bsrIn),
    .tdo      (tdo),
    .tdoEn    (tdoEn),
    .bsrOut   (bsrOut)
  );

  assign tapState = stateQ;

endmodule

// File: tb/tb_scan_tap.sv
`timescale 1ns/1ps
module tb_scan_tap;

  localparam int          BSR_LEN = 6;
  localparam logic [31:0] ID_VAL  = 32'h1A5C_E0F3;

  localparam logic [3:0] S_RESET = 4'd0,  S_IDLE = 4'd1,  S_SEL_DR = 4'd2, S_CAP_DR = 4'd3,
                         S_SH_DR = 4'd4,  S_EX1_DR = 4'd5, S_PAU_DR = 4'd6, S_EX2_DR = 4'd7,
                         S_UPD_DR = 4'd8, S_SEL_IR = 4'd9, S_CAP_IR = 4'd10, S_SH_IR = 4'd11,
                         S_EX1_IR = 4'd12, S_PAU_IR = 4'd13, S_EX2_IR = 4'd14, S_UPD_IR = 4'd15;

  localparam logic [2:0] C_EXTEST = 3'b000, C_SAMPLE = 3'b001, C_IDCODE = 3'b010, C_BYPASS = 3'b111;

  logic tck = 1'b0;
  logic trstN, tms, tdi;
  logic [BSR_LEN-1:0] bsrIn;
  logic tdo, tdoEn;
  logic [3:0] tapState;
  logic [2:0] instr;
  logic [3:0] instrDec;
  logic [BSR_LEN-1:0] bsrOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  logic [3:0] expState;
  logic [2:0] expIrSh;
  logic [2:0] expInstr;
  logic [2:0] midInstr;
  logic [BSR_LEN-1:0] midBsr;

  always #4 tck = ~tck;

  scan_tap #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VAL)) dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .bsrIn(bsrIn),
    .tdo(tdo), .tdoEn(tdoEn), .tapState(tapState), .instr(instr),
    .instrDec(instrDec), .bsrOut(bsrOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] stepModel(input logic [3:0] s, input logic t);
    case (s)
      S_RESET:  return t ? S_RESET  : S_IDLE;
      S_IDLE:   return t ? S_SEL_DR : S_IDLE;
      S_SEL_DR: return t ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR, S_SH_DR: return t ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: return t ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: return t ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: return t ? S_UPD_DR : S_SH_DR;
      S_SEL_IR: return t ? S_RESET  : S_CAP_IR;
      S_CAP_IR, S_SH_IR: return t ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: return t ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: return t ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: return t ? S_UPD_IR : S_SH_IR;
      default:  return t ? S_SEL_DR : S_IDLE;   // both Update states
    endcase
  endfunction

  function automatic logic [3:0] decodeModel(input logic [2:0] c);
    case (c)
      C_EXTEST: return 4'b1000;
      C_SAMPLE: return 4'b0100;
      C_IDCODE: return 4'b0010;
      default:  return 4'b0001;
    endcase
  endfunction

  // One tck period: called just after a falling edge, returns just after the next one
  task automatic tick(input logic tv, input logic dv, output logic seen);
    logic [3:0] nxt;
    tms = tv; tdi = dv;
    seen = tdo;
    if (expState == S_SH_DR || expState == S_SH_IR)
      chk(tdoEn === 1'b1, "R10 tdoEn in shift", tdoEn, 1);
    else
      chk(tdoEn === 1'b0 && tdo === 1'b0, "R10 idle tdo", {tdoEn, tdo}, 0);
    if (expState == S_SH_IR)
      chk(tdo === expIrSh[0], "R4 instruction serial bit", tdo, expIrSh[0]);
    if (expState == S_CAP_IR) expIrSh = 3'b100;
    else if (expState == S_SH_IR) expIrSh = {dv, expIrSh[2:1]};
    nxt = stepModel(expState, tv);
    @(posedge tck); #1;
    midInstr = instr; midBsr = bsrOut;
    @(negedge tck); #1;
    expState = nxt;
    if (nxt == S_RESET) expInstr = C_IDCODE;
    else if (nxt == S_UPD_IR) expInstr = expIrSh;
    chk(tapState === expState, "R1 state", tapState, expState);
    chk(instr === expInstr, "R5 instruction", instr, expInstr);
    chk(instrDec === decodeModel(expInstr), "R5 decode", instrDec, decodeModel(expInstr));
  endtask

  task automatic irScan(input logic [2:0] code, output logic [2:0] captured);
    logic b;
    logic [2:0] old;
    tick(1, 0, b); tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i], b);
      captured[i] = b;
    end
    old = instr;
    tick(1, 0, b);
    chk(midInstr === old, "R5 instruction held at rising edge into Update-IR", midInstr, old);
    chk(instr === code, "R5 instruction loaded on falling edge", instr, code);
    tick(0, 0, b);
  endtask

  task automatic drScan(input int n, input logic [63:0] din, input bit pause, output logic [63:0] dout);
    logic b;
    logic [BSR_LEN-1:0] old;
    dout = '0;
    tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    for (int i = 0; i < n; i++) begin
      tick((i == n - 1) || (pause && i == 2), din[i], b);
      dout[i] = b;
      if (pause && i == 2 && n > 3) begin
        tick(0, 0, b); tick(0, 1, b); tick(1, 0, b); tick(0, 1, b);
      end
    end
    old = bsrOut;
    tick(1, 0, b);
    chk(midBsr === old, "R9 bsrOut held at rising edge into Update-DR", midBsr, old);
    tick(0, 0, b);
  endtask

  initial begin
    logic b;
    logic [2:0] cap;
    logic [63:0] din, dout, expv;
    logic [BSR_LEN-1:0] pv, sv;
    void'($urandom(32'd20240));
    trstN = 0; tms = 1; tdi = 0; bsrIn = '0;
    expState = S_RESET; expInstr = C_IDCODE; expIrSh = 3'b100;
    repeat (3) @(negedge tck);
    #1;
    chk(tapState === S_RESET, "R3 reset state", tapState, S_RESET);
    chk(instr === C_IDCODE, "R3 reset instruction", instr, C_IDCODE);
    chk(instrDec === 4'b0010, "R5 reset decode", instrDec, 4'b0010);
    chk(tdoEn === 0 && tdo === 0, "R3 reset tdo", {tdoEn, tdo}, 0);
    chk(bsrOut === '0, "R3 reset bsrOut", bsrOut, 0);
    trstN = 1;
    tick(0, 0, b);

    // Identification register after reset
    din = {32'h0, 32'($urandom)};
    drScan(32, din, 0, dout);
    chk(dout[31:0] === ID_VAL, "R7 identification value", dout[31:0], ID_VAL);

    // Bypass: capture pattern and one-stage delay
    irScan(C_BYPASS, cap);
    chk(cap === 3'b100, "R4 captured pattern", cap, 3'b100);
    din = {54'h0, 10'($urandom)};
    drScan(10, din, 0, dout);
    expv = {54'h0, din[8:0], 1'b0};
    chk(dout === expv, "R6 bypass delay", dout, expv);

    // Unrecognised code falls back to bypass
    irScan(3'b100, cap);
    chk(instrDec === 4'b0001, "R5 unknown code selects bypass", instrDec, 4'b0001);
    drScan(4, 64'hF, 0, dout);
    chk(dout[3:0] === 4'b1110, "R6 bypass on unknown code", dout[3:0], 4'b1110);

    // SAMPLE/PRELOAD
    irScan(C_SAMPLE, cap);
    sv = BSR_LEN'($urandom); bsrIn = sv;
    pv = BSR_LEN'($urandom) ^ BSR_LEN'(6'h2A);
    drScan(BSR_LEN, {{(64-BSR_LEN){1'b0}}, pv}, 0, dout);
    chk(dout[BSR_LEN-1:0] === sv, "R8 sample of bsrIn", dout[BSR_LEN-1:0], sv);
    chk(bsrOut === pv, "R9 preload to bsrOut", bsrOut, pv);

    // EXTEST with a pause in the middle of the scan
    irScan(C_EXTEST, cap);
    sv = ~sv; bsrIn = sv;
    pv = ~pv ^ BSR_LEN'(1);
    drScan(BSR_LEN, {{(64-BSR_LEN){1'b0}}, pv}, 1, dout);
    chk(dout[BSR_LEN-1:0] === sv, "R11 paused scan output", dout[BSR_LEN-1:0], sv);
    chk(bsrOut === pv, "R11 paused scan update", bsrOut, pv);

    // IDCODE scan leaves bsrOut untouched
    irScan(C_IDCODE, cap);
    bsrIn = ~bsrIn;
    drScan(32, {32'h0, 32'($urandom)}, 1, dout);
    chk(dout[31:0] === ID_VAL, "R7 identification after pause", dout[31:0], ID_VAL);
    chk(bsrOut === pv, "R9 bsrOut unchanged under IDCODE", bsrOut, pv);

    // Constrained-random walk over the graph
    for (int k = 0; k < 600; k++)
      tick(($urandom % 3) == 0, 1'($urandom), b);

    // Five high edges reach reset from random states
    for (int r = 0; r < 10; r++) begin
      for (int k = 0; k < int'($urandom % 9); k++)
        tick(1'($urandom), 1'($urandom), b);
      repeat (5) tick(1, 0, b);
      chk(tapState === S_RESET, "R2 five high edges", tapState, S_RESET);
      tick(1, 0, b);
      chk(tapState === S_RESET, "R2 stays in reset", tapState, S_RESET);
    end

    // Asynchronous reset in the middle of a shift
    tick(0, 0, b);
    irScan(C_SAMPLE, cap);
    tick(1, 0, b); tick(0, 0, b); tick(0, 0, b); tick(0, 1, b);
    #2 trstN = 0; #1;
    chk(tapState === S_RESET, "R3 async state", tapState, S_RESET);
    chk(instr === C_IDCODE, "R3 async instruction", instr, C_IDCODE);
    chk(tdoEn === 0 && tdo === 0, "R3 async tdo", {tdoEn, tdo}, 0);
    chk(bsrOut === '0, "R3 async bsrOut", bsrOut, 0);
    expState = S_RESET; expInstr = C_IDCODE;
    @(negedge tck); #1 trstN = 1;
    tick(0, 0, b);
    drScan(32, 64'h0, 0, dout);
    chk(dout[31:0] === ID_VAL, "R7 identification after async reset", dout[31:0], ID_VAL);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule